// File: doc/BRIEF.md
# Buffered Timer/Counter with Dual Capture

This block is one 16-bit timer/counter channel. It advances on a strobe input. A power-of-two divider can thin that strobe, so the channel steps once every 1 to 128 strobes. The channel counts up, down, or up-then-down between zero and a period value. It either keeps running or halts after its first terminal count. Single-cycle strobes start, stop and reload the counter. Two further strobes each snapshot the live count into one of two compare/capture registers.

Software-style writes never touch the active period or compare values directly. They land in a buffer behind each one, and all three buffers are copied to the active registers in the same cycle that a terminal count occurs. A capture pushes the previous capture value into that buffer, so each channel keeps its last two samples.

The counter raises single-cycle pulses for overflow, underflow, terminal count and the two compare matches. The terminal-count and match pulses also set three sticky flags. A mask selects which flags drive the single interrupt line, and a write-one strobe clears flags.

Top module: `tmr_capture`

## Requirements
- R1: After reset the count, the active period, both compare/capture registers and their buffers, the flags and all pulses are 0, the counter is stopped and irq is low.
- R2: With mode_dir=0 (up), each step adds one to the count. A step taken at count==period loads 0 and raises ovf and tc for one cycle.
- R3: With mode_dir=1 (down), each step subtracts one from the count. A step taken at count 0 loads the period and raises unf and tc for one cycle.
- R4: With mode_dir=2 or 3 (up/down, period of at least 1), the count climbs to the period and then falls back to 0. ovf pulses alongside the count that reaches the period. unf and tc pulse alongside the count that reaches 0. ovf and unf never pulse together.
- R5: With oneshot_en=1, the step that produces a terminal count also stops the counter. The count keeps the value that step produced.
- R6: While running, the counter steps once for every 2^presc_sel assertions of ev_count. Start and reload restart the divider.
- R7: ev_stop halts the counter. While it is stopped, ev_count has no effect on the count. ev_start resumes it without changing the count. Priority is stop, then reload, then start, then a step.
- R8: ev_reload sets the count to the period in down mode and to 0 in the other modes, and sets the counter running.
- R9: wr_per, wr_cc0 and wr_cc1 write wr_data into buffers only. Each buffer is copied to its active register in the cycle tc is raised.
- R10: ev_cap0 (ev_cap1) loads the current count into cc0 (cc1) and moves the old cc0 (cc1) value into cc0_buf (cc1_buf).
- R11: cc0_match (cc1_match) pulses for one cycle alongside a stepped count equal to the cc0 (cc1) value held before that step.
- R12: flags bit 0 = terminal count, bit 1 = cc0 match, bit 2 = cc1 match. Each flag sets with its pulse and stays set until a 1 in the matching bit of irq_clr; a set in the same cycle wins. irq is high when any flag that irq_mask enables is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_dir | input | 2 | 0 up, 1 down, 2/3 up/down |
| oneshot_en | input | 1 | Stop after first terminal count |
| presc_sel | input | 3 | Step divider exponent (divide by 2^n) |
| ev_start | input | 1 | Start strobe |
| ev_reload | input | 1 | Reload strobe |
| ev_stop | input | 1 | Stop strobe |
| ev_count | input | 1 | Count strobe |
| ev_cap0 | input | 1 | Capture strobe, channel 0 |
| ev_cap1 | input | 1 | Capture strobe, channel 1 |
| wr_per | input | 1 | Write period buffer |
| wr_cc0 | input | 1 | Write cc0 buffer |
| wr_cc1 | input | 1 | Write cc1 buffer |
| wr_data | input | 16 | Write data |
| irq_mask | input | 3 | Interrupt enables per flag |
| irq_clr | input | 3 | Write-one flag clear |
| count | output | 16 | Current count |
| running | output | 1 | Counter running |
| period | output | 16 | Active period |
| cc0 | output | 16 | Active compare/capture 0 |
| cc0_buf | output | 16 | Buffer behind cc0 |
| cc1 | output | 16 | Active compare/capture 1 |
| cc1_buf | output | 16 | Buffer behind cc1 |
| ovf | output | 1 | Overflow pulse |
| unf | output | 1 | Underflow pulse |
| tc | output | 1 | Terminal-count pulse |
| cc0_match | output | 1 | Match pulse, channel 0 |
| cc1_match | output | 1 | Match pulse, channel 1 |
| flags | output | 3 | Sticky event flags |
| irq | output | 1 | Interrupt |

## Verification
The wrap and peak properties assume that mode_dir, oneshot_en and presc_sel stay fixed while the counter runs. They also assume that up/down mode uses a period of at least 1 with the count inside 0..period. The stimulus respects this: it stops the counter before changing any configuration input and always follows the change with a reload. It also makes every change at a falling edge after the previous pulses have cleared. Up/down runs use a nonzero period and start from a reload, so the count never leaves its range.

// File: rtl/tmr_capture.sv
module tmr_capture #(
  parameter int W   = 16,
  parameter int PSW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     mode_dir,
  input  logic           oneshot_en,
  input  logic [PSW-1:0] presc_sel,
  input  logic           ev_start,
  input  logic           ev_reload,
  input  logic           ev_stop,
  input  logic           ev_count,
  input  logic           ev_cap0,
  input  logic           ev_cap1,
  input  logic           wr_per,
  input  logic           wr_cc0,
  input  logic           wr_cc1,
  input  logic [W-1:0]   wr_data,
  input  logic [2:0]     irq_mask,
  input  logic [2:0]     irq_clr,
  output logic [W-1:0]   count,
  output logic           running,
  output logic [W-1:0]   period,
  output logic [W-1:0]   cc0,
  output logic [W-1:0]   cc0_buf,
  output logic [W-1:0]   cc1,
  output logic [W-1:0]   cc1_buf,
  output logic           ovf,
  output logic           unf,
  output logic           tc,
  output logic           cc0_match,
  output logic           cc1_match,
  output logic [2:0]     flags,
  output logic           irq
);
  localparam logic [1:0] M_UP = 2'd0, M_DN = 2'd1;
  localparam int DW = (1 << PSW) - 1;

  logic [DW-1:0] pre_q, pre_lim;
  logic [DW:0]   pre_sh;
  logic [W-1:0]  per_buf, nxt;
  logic          dn_q, dn_nxt, o_n, u_n, t_n, fire;
  logic [2:0]    set_v;

  assign pre_sh  = {{DW{1'b0}}, 1'b1} << presc_sel;
  assign pre_lim = pre_sh[DW-1:0] - 1'b1;
  assign fire    = running & ev_count & (pre_q == pre_lim) & ~ev_stop & ~ev_reload & ~ev_start;
  assign set_v   = fire ? {nxt == cc1, nxt == cc0, t_n} : 3'b000;
  assign irq     = |(flags & irq_mask);

  always_comb begin
    nxt = count; dn_nxt = dn_q; o_n = 1'b0; u_n = 1'b0; t_n = 1'b0;
    case (mode_dir)
      M_UP: if (count == period) begin nxt = '0; o_n = 1'b1; t_n = 1'b1; end
            else nxt = count + 1'b1;
      M_DN: if (count == '0) begin nxt = period; u_n = 1'b1; t_n = 1'b1; end
            else nxt = count - 1'b1;
      default:
        if (!dn_q) begin
          nxt = count + 1'b1;
          if (nxt == period) begin o_n = 1'b1; dn_nxt = 1'b1; end
        end else begin
          nxt = count - 1'b1;
          if (nxt == '0) begin u_n = 1'b1; t_n = 1'b1; dn_nxt = 1'b0; end
        end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0; running <= 1'b0; dn_q <= 1'b0; pre_q <= '0;
      {ovf, unf, tc, cc0_match, cc1_match} <= '0;
      flags <= '0;
    end else begin
      {ovf, unf, tc} <= fire ? {o_n, u_n, t_n} : 3'b000;
      {cc1_match, cc0_match} <= set_v[2:1];
      flags <= (flags & ~irq_clr) | set_v;
      if (ev_stop) running <= 1'b0;
      else if (ev_reload) begin
        running <= 1'b1; pre_q <= '0; dn_q <= 1'b0;
        count <= (mode_dir == M_DN) ? period : '0;
      end else if (ev_start) begin
        running <= 1'b1; pre_q <= '0;
      end else if (running && ev_count) begin
        if (fire) begin
          pre_q <= '0; count <= nxt; dn_q <= dn_nxt;
          if (t_n && oneshot_en) running <= 1'b0;
        end else pre_q <= pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period <= '0; per_buf <= '0;
      cc0 <= '0; cc0_buf <= '0; cc1 <= '0; cc1_buf <= '0;
    end else begin
      if (fire && t_n) period <= per_buf;
      if (wr_per) per_buf <= wr_data;
      if (ev_cap0) begin cc0 <= count; cc0_buf <= cc0; end
      else begin
        if (fire && t_n) cc0 <= cc0_buf;
        if (wr_cc0) cc0_buf <= wr_data;
      end
      if (ev_cap1) begin cc1 <= count; cc1_buf <= cc1; end
      else begin
        if (fire && t_n) cc1 <= cc1_buf;
        if (wr_cc1) cc1_buf <= wr_data;
      end
    end
  end

  p_stopped_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !ev_reload) |=> $stable(count));
  p_up_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_dir == M_UP && ovf) |-> count == '0);
  p_down_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_dir == M_DN && unf) |-> count == $past(period));
  p_peak_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_dir[1] && ovf) |-> count == period);
  p_one_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ovf, unf}));
  p_oneshot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (oneshot_en && tc) |-> !running);
  p_swap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> period == $past(per_buf));
  p_capture_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cap0 |=> (cc0 == $past(count) && cc0_buf == $past(cc0)));
  p_match_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cc0_match |-> count == $past(cc0));
  p_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> flags[0]);
endmodule

// File: tb/tmr_capture_test.sv
module tmr_capture_test;
  logic clk = 0, rst_n = 0;
  logic [1:0] mode_dir = 0;
  logic oneshot_en = 0;
  logic [2:0] presc_sel = 0;
  logic ev_start = 0, ev_reload = 0, ev_stop = 0, ev_count = 0, ev_cap0 = 0, ev_cap1 = 0;
  logic wr_per = 0, wr_cc0 = 0, wr_cc1 = 0;
  logic [15:0] wr_data = 0;
  logic [2:0] irq_mask = 0, irq_clr = 0;
  logic [15:0] count, period, cc0, cc0_buf, cc1, cc1_buf;
  logic running, ovf, unf, tc, cc0_match, cc1_match, irq;
  logic [2:0] flags;
  int compared = 0, mismatched = 0;

  always #5 clk = ~clk;

  tmr_capture uut (.clk(clk), .rst_n(rst_n), .mode_dir(mode_dir), .oneshot_en(oneshot_en),
    .presc_sel(presc_sel), .ev_start(ev_start), .ev_reload(ev_reload), .ev_stop(ev_stop),
    .ev_count(ev_count), .ev_cap0(ev_cap0), .ev_cap1(ev_cap1), .wr_per(wr_per),
    .wr_cc0(wr_cc0), .wr_cc1(wr_cc1), .wr_data(wr_data), .irq_mask(irq_mask),
    .irq_clr(irq_clr), .count(count), .running(running), .period(period), .cc0(cc0),
    .cc0_buf(cc0_buf), .cc1(cc1), .cc1_buf(cc1_buf), .ovf(ovf), .unf(unf), .tc(tc),
    .cc0_match(cc0_match), .cc1_match(cc1_match), .flags(flags), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    ev_count = 1; @(negedge clk); ev_count = 0;
  endtask
  task automatic reload();
    ev_reload = 1; @(negedge clk); ev_reload = 0;
  endtask
  task automatic stop();
    ev_stop = 1; @(negedge clk); ev_stop = 0;
  endtask
  task automatic start();
    ev_start = 1; @(negedge clk); ev_start = 0;
  endtask
  task automatic wr(input int which, input logic [15:0] d);
    wr_data = d;
    case (which) 0: wr_per = 1; 1: wr_cc0 = 1; default: wr_cc1 = 1; endcase
    @(negedge clk); wr_per = 0; wr_cc0 = 0; wr_cc1 = 0;
  endtask

  task automatic setup(input logic [1:0] dir, input logic [15:0] p, input logic [15:0] c0,
                       input logic [15:0] c1);
    rst_n = 0; mode_dir = 0; oneshot_en = 0; presc_sel = 0; irq_mask = 0; irq_clr = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    wr(0, p); wr(1, c0); wr(2, c1);
    reload(); step(); stop();
    mode_dir = dir; irq_clr = 3'b111; @(negedge clk); irq_clr = 0;
    reload();
  endtask

  task automatic t_reset();
    rst_n = 0; repeat (2) @(negedge clk); rst_n = 1; @(negedge clk);
    chk("R1 count", count, 0); chk("R1 running", running, 0);
    chk("R1 period", period, 0); chk("R1 cc regs", {cc0, cc1}, 0);
    chk("R1 flags", flags, 0); chk("R1 irq", irq, 0);
  endtask

  task automatic t_up();
    setup(2'd0, 3, 2, 1);
    chk("R8 up reload count", count, 0); chk("R8 running", running, 1);
    step(); chk("R2 count", count, 1); chk("R11 cc1 match", {cc1_match, cc0_match}, 2'b10);
    step(); chk("R11 cc0 match", {cc1_match, cc0_match}, 2'b01);
    wr(0, 5); chk("R9 period held", period, 3);
    step(); chk("R2 count 3", count, 3); chk("R2 no ovf", ovf, 0);
    ev_count = 1; irq_clr = 3'b001; @(negedge clk); ev_count = 0; irq_clr = 0;
    chk("R2 wrap", count, 0); chk("R2 ovf/tc/unf", {ovf, tc, unf}, 3'b110);
    chk("R9 period swapped", period, 5);
    chk("R12 set beats clear", flags, 3'b111);
    chk("R12 masked off", irq, 0);
    irq_mask = 3'b001; #1 chk("R12 irq on", irq, 1);
    irq_clr = 3'b001; @(negedge clk); irq_clr = 0;
    chk("R12 cleared", flags, 3'b110); chk("R12 irq off", irq, 0);
  endtask

  task automatic t_down();
    setup(2'd1, 2, 1, 9);
    chk("R8 down reload", count, 2);
    step(); chk("R3 count", count, 1); chk("R11 match", cc0_match, 1);
    step(); chk("R3 zero", count, 0);
    step(); chk("R3 wrap", count, 2); chk("R3 unf/tc/ovf", {unf, tc, ovf}, 3'b110);
  endtask

  task automatic t_updown();
    setup(2'd2, 2, 9, 9);
    step(); chk("R4 c1", count, 1); chk("R4 no ovf", ovf, 0);
    step(); chk("R4 peak", count, 2); chk("R4 ovf/tc", {ovf, tc, unf}, 3'b100);
    step(); chk("R4 fall", count, 1);
    step(); chk("R4 zero", count, 0); chk("R4 unf/tc", {ovf, tc, unf}, 3'b011);
    step(); chk("R4 rise", count, 1);
  endtask

  task automatic t_oneshot();
    setup(2'd0, 2, 9, 9); stop(); oneshot_en = 1; reload();
    step(); step(); chk("R5 count 2", count, 2);
    step(); chk("R5 tc", tc, 1); chk("R5 stopped", running, 0); chk("R5 count", count, 0);
    step(); step(); chk("R7 ignored", count, 0);
  endtask

  task automatic t_presc();
    setup(2'd0, 10, 99, 99); stop(); presc_sel = 2; reload();
    repeat (3) step(); chk("R6 no step yet", count, 0);
    step(); chk("R6 first step", count, 1);
    repeat (4) step(); chk("R6 second step", count, 2);
  endtask

  task automatic t_stopstart();
    setup(2'd0, 10, 99, 99);
    repeat (3) step(); stop();
    chk("R7 stopped", running, 0);
    step(); step(); chk("R7 held", count, 3);
    start(); chk("R7 resumed", {running, count}, {1'b1, 16'd3});
    step(); chk("R7 step", count, 4);
    reload(); chk("R8 mid reload", count, 0);
  endtask

  task automatic t_capture();
    setup(2'd0, 10, 7, 9);
    repeat (4) step();
    ev_cap0 = 1; @(negedge clk); ev_cap0 = 0;
    chk("R10 cap0", {cc0, cc0_buf}, {16'd4, 16'd7});
    step(); step();
    ev_cap0 = 1; ev_cap1 = 1; @(negedge clk); ev_cap0 = 0; ev_cap1 = 0;
    chk("R10 cap0 again", {cc0, cc0_buf}, {16'd6, 16'd4});
    chk("R10 cap1", {cc1, cc1_buf}, {16'd6, 16'd9});
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog actual=hung expected=done");
    report();
  end

  initial begin
    @(negedge clk);
    t_reset(); t_up(); t_down(); t_updown(); t_oneshot(); t_presc(); t_stopstart(); t_capture();
    report();
  end
endmodule